// File: doc/BRIEF.md
# Global Reset Sequencer with Boot Vector Load

This block is the single point that decides when a 16-bit processor and its peripherals are held in reset and when they may run. It merges three causes of reset: a power-on indication, an external reset pin and a watchdog overflow pulse. It holds a global reset long enough for the clock source to settle and then for a fixed number of machine cycles more. The external pin is brought into the clock domain by a two-flop synchronizer. After that it is looked at only on clocks where the machine-cycle strobe is high, so the pin responds once per machine cycle and not on every clock.

Once the global reset is released, the block loads the boot vectors itself. It reads four consecutive 16-bit words from the vector area over a simple request/ready read bus and assembles them into the supervisor stack pointer and the program counter. Only when both values are in place does it raise the status-register interrupt mask to 7 and flag that execution may begin. A new reset cause during the load, or while running, aborts everything and starts again from the hold phase.

A separate software reset request drives only the peripheral reset, for as long as it is held. It leaves the processor, the loaded vectors and the running flag alone. The watchdog-disable output is active whenever the global reset is active.

Top module: `rstvec_ctrl`

## Requirements
- R1: `ext_rst_i` passes through two synchronizing flops and is then captured only on clock edges where `mc_stb_i` is high. A pulse that has left the synchronizer before the next strobe has no effect on any output.
- R2: Each reset cause asserts `global_rst_o`. `por_i` asserts it at once (asynchronously), a one-clock `wdt_ovf_i` pulse asserts it on the next clock, and a held `ext_rst_i` asserts it within 2 + one machine-cycle period + 1 clocks.
- R3: After the last clock on which a reset cause is seen, `global_rst_o` stays high for `OSC_CYCLES` clocks and then for `HOLD_MC` further machine-cycle strobes. Both counts start over whenever any cause reappears.
- R4: After release, exactly four reads are made, at byte addresses `VEC_BASE`+0, +2, +4 and +6 in that order. While `rd_req_o` is high and `rd_ready_i` is low, `rd_addr_o` does not change. A word is taken on a clock where both are high.
- R5: The words are assembled most-significant half first. The word at +0 is `ssp_o[31:16]`, +2 is `ssp_o[15:0]`, +4 is `pc_o[31:16]` and +6 is `pc_o[15:0]`.
- R6: `sr_ipl_o` reads 0 until the fourth word is accepted. On the clock after that acceptance, `sr_ipl_o` becomes 7 and `running_o` becomes 1 together.
- R7: A reset cause seen during the load or while running aborts it. On the next clock `running_o`, `rd_req_o`, `sr_ipl_o`, `ssp_o` and `pc_o` are all 0, and the load later restarts at offset +0.
- R8: `wdt_dis_o` is high on every clock on which `global_rst_o` is high, and low otherwise.
- R9: `periph_rst_o` is high whenever `global_rst_o` or `sw_rst_i` is high, in the same cycle. `sw_rst_i` changes neither `global_rst_o`, `running_o`, `ssp_o` nor `pc_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_i | input | 1 | Power-on indication, active high; also clears the block asynchronously |
| ext_rst_i | input | 1 | External reset pin, active high, asynchronous to clk |
| mc_stb_i | input | 1 | One-clock machine-cycle strobe |
| wdt_ovf_i | input | 1 | Watchdog overflow pulse |
| sw_rst_i | input | 1 | Software request to reset peripherals only |
| rd_req_o | output | 1 | Vector read request |
| rd_addr_o | output | ADDR_W | Byte address of the vector word being read |
| rd_ready_i | input | 1 | Read data valid; completes the current word |
| rd_data_i | input | DATA_W | Read data word |
| global_rst_o | output | 1 | Reset to processor and peripherals |
| periph_rst_o | output | 1 | Reset to peripherals only |
| wdt_dis_o | output | 1 | Holds the watchdog disabled |
| ssp_o | output | 2*DATA_W | Loaded supervisor stack pointer |
| pc_o | output | 2*DATA_W | Loaded program counter |
| sr_ipl_o | output | 3 | Status-register interrupt mask level |
| running_o | output | 1 | Boot sequence complete, execution may begin |

## Verification
The bench builds the block with `OSC_CYCLES` = 20 and `HOLD_MC` = 2 and drives a strobe every 4 clocks. This makes a full hold phase about 25 to 28 clocks long, so dozens of complete reset, load and abort cycles fit into one run. It also lets the exact bounds on the hold length be checked for every cause. The short strobe period places a one-clock pin pulse squarely between two strobes to show that it is ignored. Randomized ready delays and aborts at any vector word exercise the address-hold and restart paths.

// File: rtl/rstvec_pkg.sv
package rstvec_pkg;

    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_FETCH = 2'd1,
        FS_RUN   = 2'd2
    } fetch_state_e;

    localparam int VEC_WORDS = 4;
    localparam logic [2:0] IPL_MAX = 3'h7;

endpackage

// File: rtl/rstvec_sampler.sv
module rstvec_sampler (
    input  logic clk,
    input  logic por_i,
    input  logic pin_i,
    input  logic mc_stb_i,
    output logic smp_o
);

    typedef struct packed {
        logic s1;
        logic s2;
        logic smp;
    } samp_t;

    samp_t q, d;

    always_comb begin
        d     = q;
        d.s1  = pin_i;
        d.s2  = q.s1;
        if (mc_stb_i) begin
            d.smp = q.s2;
        end
    end

    always_ff @(posedge clk or posedge por_i) begin
        if (por_i) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign smp_o = q.smp;

    // R1: the captured value moves only on strobe clocks
    assert_hold_between_strobes_R1: assert property (@(posedge clk) disable iff (por_i)
        !mc_stb_i |=> $stable(smp_o));

    // R1: on a strobe the synchronized pin value is captured
    assert_capture_on_strobe_R1: assert property (@(posedge clk) disable iff (por_i)
        mc_stb_i |=> smp_o == $past(q.s2));

endmodule

// File: rtl/rstvec_hold.sv
module rstvec_hold #(
    parameter int OSC_CYCLES = 1000,
    parameter int HOLD_MC    = 2
) (
    input  logic clk,
    input  logic por_i,
    input  logic src_i,
    input  logic mc_stb_i,
    output logic holding_o,
    output logic release_o
);

    localparam int OW = (OSC_CYCLES < 1) ? 1 : $clog2(OSC_CYCLES + 1);
    localparam int MW = (HOLD_MC < 2) ? 1 : $clog2(HOLD_MC + 1);
    localparam logic [OW-1:0] OSC_END = OW'(OSC_CYCLES);
    localparam logic [MW-1:0] MC_LAST = MW'(HOLD_MC - 1);

    typedef struct packed {
        logic          holding;
        logic [OW-1:0] osc;
        logic [MW-1:0] mc;
    } hold_t;

    hold_t q, d;
    logic  rel;

    always_comb begin
        d   = q;
        rel = 1'b0;
        if (src_i) begin
            d.holding = 1'b1;
            d.osc     = '0;
            d.mc      = '0;
        end else if (q.holding) begin
            if (q.osc != OSC_END) begin
                d.osc = q.osc + 1'b1;
            end else if (mc_stb_i) begin
                if (q.mc == MC_LAST) begin
                    d.holding = 1'b0;
                    d.mc      = '0;
                    rel       = 1'b1;
                end else begin
                    d.mc = q.mc + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or posedge por_i) begin
        if (por_i) begin
            q <= '{holding: 1'b1, osc: '0, mc: '0};
        end else begin
            q <= d;
        end
    end

    assign holding_o = q.holding;
    assign release_o = rel;

    // checker: clocks since the last reset cause, saturating at OSC_CYCLES
    logic [OW:0] quiet_q;
    always_ff @(posedge clk or posedge por_i) begin
        if (por_i) begin
            quiet_q <= '0;
        end else if (src_i) begin
            quiet_q <= '0;
        end else if (quiet_q < (OW+1)'(OSC_CYCLES)) begin
            quiet_q <= quiet_q + 1'b1;
        end
    end

    // R3: no release before the settle time has fully elapsed
    assert_min_settle_R3: assert property (@(posedge clk) disable iff (por_i)
        release_o |-> quiet_q >= (OW+1)'(OSC_CYCLES));

    // R3: any cause re-arms the hold
    assert_rearm_R3: assert property (@(posedge clk) disable iff (por_i)
        src_i |=> holding_o);

    // R3: release only lands on a strobe
    assert_release_on_strobe_R3: assert property (@(posedge clk) disable iff (por_i)
        $fell(holding_o) |-> $past(mc_stb_i));

endmodule

// File: rtl/rstvec_fetch.sv
module rstvec_fetch
    import rstvec_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int DATA_W   = 16,
    parameter int VEC_BASE = 0
) (
    input  logic                clk,
    input  logic                por_i,
    input  logic                src_i,
    input  logic                release_i,
    output logic                rd_req_o,
    output logic [ADDR_W-1:0]   rd_addr_o,
    input  logic                rd_ready_i,
    input  logic [DATA_W-1:0]   rd_data_i,
    output logic [2*DATA_W-1:0] ssp_o,
    output logic [2*DATA_W-1:0] pc_o,
    output logic [2:0]          ipl_o,
    output logic                running_o
);

    localparam int WW   = $clog2(VEC_WORDS);
    localparam int STEP = DATA_W / 8;
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(VEC_BASE);
    localparam logic [WW-1:0] LAST_W = WW'(VEC_WORDS - 1);

    typedef struct packed {
        fetch_state_e        state;
        logic [WW-1:0]       word;
        logic [2*DATA_W-1:0] ssp;
        logic [2*DATA_W-1:0] pc;
        logic [2:0]          ipl;
    } fetch_t;

    fetch_t q, d;

    always_comb begin
        d = q;
        if (src_i) begin
            d.state = FS_IDLE;
            d.word  = '0;
            d.ssp   = '0;
            d.pc    = '0;
            d.ipl   = '0;
        end else begin
            case (q.state)
                FS_IDLE: begin
                    if (release_i) begin
                        d.state = FS_FETCH;
                        d.word  = '0;
                    end
                end
                FS_FETCH: begin
                    if (rd_ready_i) begin
                        case (q.word)
                            2'd0:    d.ssp[2*DATA_W-1:DATA_W] = rd_data_i;
                            2'd1:    d.ssp[DATA_W-1:0]        = rd_data_i;
                            2'd2:    d.pc[2*DATA_W-1:DATA_W]  = rd_data_i;
                            default: d.pc[DATA_W-1:0]         = rd_data_i;
                        endcase
                        d.word = q.word + 1'b1;
                        if (q.word == LAST_W) begin
                            d.state = FS_RUN;
                            d.ipl   = IPL_MAX;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or posedge por_i) begin
        if (por_i) begin
            q <= '{state: FS_IDLE, word: '0, ssp: '0, pc: '0, ipl: '0};
        end else begin
            q <= d;
        end
    end

    assign rd_req_o  = (q.state == FS_FETCH);
    assign rd_addr_o = BASE + ADDR_W'(q.word) * ADDR_W'(STEP);
    assign ssp_o     = q.ssp;
    assign pc_o      = q.pc;
    assign ipl_o     = q.ipl;
    assign running_o = (q.state == FS_RUN);

    // R4: a pending read keeps its request and address
    assert_addr_hold_R4: assert property (@(posedge clk) disable iff (por_i)
        rd_req_o && !rd_ready_i && !src_i |=> rd_req_o && $stable(rd_addr_o));

    // R6: running only follows acceptance of the last word
    assert_run_after_last_R6: assert property (@(posedge clk) disable iff (por_i)
        $rose(running_o) |-> $past(rd_ready_i && rd_req_o && rd_addr_o == BASE + ADDR_W'(3 * STEP)));

    // R6: mask level is 7 exactly while running
    assert_ipl_level_R6: assert property (@(posedge clk) disable iff (por_i)
        running_o |-> ipl_o == IPL_MAX);

    // R6: mask stays 0 while the vectors are incomplete
    assert_ipl_zero_R6: assert property (@(posedge clk) disable iff (por_i)
        !running_o |-> ipl_o == 3'd0);

    // R7: a reset cause clears the loaded state on the next clock
    assert_abort_R7: assert property (@(posedge clk) disable iff (por_i)
        src_i |=> !running_o && !rd_req_o && ssp_o == '0 && pc_o == '0);

endmodule

// File: rtl/rstvec_ctrl.sv
module rstvec_ctrl #(
    parameter int OSC_CYCLES = 1000,
    parameter int HOLD_MC    = 2,
    parameter int ADDR_W     = 24,
    parameter int DATA_W     = 16,
    parameter int VEC_BASE   = 0
) (
    input  logic                clk,
    input  logic                por_i,
    input  logic                ext_rst_i,
    input  logic                mc_stb_i,
    input  logic                wdt_ovf_i,
    input  logic                sw_rst_i,
    output logic                rd_req_o,
    output logic [ADDR_W-1:0]   rd_addr_o,
    input  logic                rd_ready_i,
    input  logic [DATA_W-1:0]   rd_data_i,
    output logic                global_rst_o,
    output logic                periph_rst_o,
    output logic                wdt_dis_o,
    output logic [2*DATA_W-1:0] ssp_o,
    output logic [2*DATA_W-1:0] pc_o,
    output logic [2:0]          sr_ipl_o,
    output logic                running_o
);

    logic ext_smp;
    logic src;
    logic holding;
    logic release_pulse;

    rstvec_sampler u_sampler (
        .clk      (clk),
        .por_i    (por_i),
        .pin_i    (ext_rst_i),
        .mc_stb_i (mc_stb_i),
        .smp_o    (ext_smp)
    );

    assign src = por_i | ext_smp | wdt_ovf_i;

    rstvec_hold #(
        .OSC_CYCLES (OSC_CYCLES),
        .HOLD_MC    (HOLD_MC)
    ) u_hold (
        .clk       (clk),
        .por_i     (por_i),
        .src_i     (src),
        .mc_stb_i  (mc_stb_i),
        .holding_o (holding),
        .release_o (release_pulse)
    );

    rstvec_fetch #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .VEC_BASE (VEC_BASE)
    ) u_fetch (
        .clk        (clk),
        .por_i      (por_i),
        .src_i      (src),
        .release_i  (release_pulse),
        .rd_req_o   (rd_req_o),
        .rd_addr_o  (rd_addr_o),
        .rd_ready_i (rd_ready_i),
        .rd_data_i  (rd_data_i),
        .ssp_o      (ssp_o),
        .pc_o       (pc_o),
        .ipl_o      (sr_ipl_o),
        .running_o  (running_o)
    );

    assign global_rst_o = holding;
    assign wdt_dis_o    = holding;
    assign periph_rst_o = holding | sw_rst_i;

    // R2: a watchdog pulse reaches the global reset on the next clock
    assert_wdt_reset_R2: assert property (@(posedge clk) disable iff (por_i)
        wdt_ovf_i |=> global_rst_o);

    // R8: a watchdog pulse leaves the watchdog disabled
    assert_wdt_disable_R8: assert property (@(posedge clk) disable iff (por_i)
        wdt_ovf_i |=> wdt_dis_o);

    // R9: software reset does not stop a running processor
    assert_sw_keeps_run_R9: assert property (@(posedge clk) disable iff (por_i)
        sw_rst_i && running_o && !src |=> running_o && $stable(pc_o) && $stable(ssp_o));

endmodule

// File: tb/rstvec_ctrl_tb.sv
module rstvec_ctrl_tb;

    localparam int OSC  = 20;
    localparam int HMC  = 2;
    localparam int MCP  = 4;
    localparam int AW   = 24;
    localparam int DW   = 16;
    localparam int BASE = 0;
    localparam int HOLD_MIN = OSC + (HMC - 1) * MCP + 1;
    localparam int HOLD_MAX = OSC + HMC * MCP;

    logic          clk = 1'b0;
    logic          por_i = 1'b1;
    logic          ext_rst_i = 1'b0;
    logic          mc_stb_i = 1'b0;
    logic          wdt_ovf_i = 1'b0;
    logic          sw_rst_i = 1'b0;
    logic          rd_req_o;
    logic [AW-1:0] rd_addr_o;
    logic          rd_ready_i = 1'b0;
    logic [DW-1:0] rd_data_i = '0;
    logic          global_rst_o, periph_rst_o, wdt_dis_o, running_o;
    logic [31:0]   ssp_o, pc_o;
    logic [2:0]    sr_ipl_o;

    always #5 clk = ~clk;

    rstvec_ctrl #(
        .OSC_CYCLES (OSC),
        .HOLD_MC    (HMC),
        .ADDR_W     (AW),
        .DATA_W     (DW),
        .VEC_BASE   (BASE)
    ) u_dut (
        .clk (clk), .por_i (por_i), .ext_rst_i (ext_rst_i), .mc_stb_i (mc_stb_i),
        .wdt_ovf_i (wdt_ovf_i), .sw_rst_i (sw_rst_i), .rd_req_o (rd_req_o),
        .rd_addr_o (rd_addr_o), .rd_ready_i (rd_ready_i), .rd_data_i (rd_data_i),
        .global_rst_o (global_rst_o), .periph_rst_o (periph_rst_o), .wdt_dis_o (wdt_dis_o),
        .ssp_o (ssp_o), .pc_o (pc_o), .sr_ipl_o (sr_ipl_o), .running_o (running_o)
    );

    int          checks = 0;
    int          fails  = 0;
    logic [15:0] vec_mem [4];
    int          exp_idx = 0;
    int          rdy_pct = 50;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_ssp();
        return {vec_mem[0], vec_mem[1]};
    endfunction

    function automatic logic [31:0] exp_pc();
        return {vec_mem[2], vec_mem[3]};
    endfunction

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic strobe_gen();
        int ph = 0;
        forever begin
            @(negedge clk);
            ph = (ph + 1) % MCP;
            mc_stb_i = (ph == 0);
        end
    endtask

    task automatic responder();
        bit            pend = 1'b0;
        logic [AW-1:0] prev_addr = '0;
        forever begin
            @(negedge clk);
            if (global_rst_o) exp_idx = 0;
            if (rd_req_o) begin
                if (pend)
                    chk(rd_addr_o == prev_addr, "R4", "address held while waiting", rd_addr_o, prev_addr);
                if (($urandom % 100) < rdy_pct) begin
                    chk(rd_addr_o == AW'(BASE + 2 * exp_idx), "R4", "vector read address",
                        rd_addr_o, AW'(BASE + 2 * exp_idx));
                    rd_ready_i = 1'b1;
                    rd_data_i  = vec_mem[exp_idx % 4];
                    exp_idx++;
                    pend = 1'b0;
                end else begin
                    rd_ready_i = 1'b0;
                    rd_data_i  = DW'($urandom);
                    pend = 1'b1;
                    prev_addr = rd_addr_o;
                end
            end else begin
                rd_ready_i = 1'b0;
                pend = 1'b0;
            end
        end
    endtask

    task automatic new_vectors();
        for (int i = 0; i < 4; i++) vec_mem[i] = 16'($urandom);
    endtask

    // counts clocks of global reset from the current sample onward
    task automatic check_hold(input string src_name);
        int cnt = 0;
        while (global_rst_o && cnt < 1000) begin
            chk(wdt_dis_o == 1'b1, "R8", "watchdog disabled during reset", wdt_dis_o, 1);
            cnt++;
            step();
        end
        chk(cnt >= HOLD_MIN && cnt <= HOLD_MAX, "R3", {"hold length after ", src_name},
            cnt, HOLD_MIN);
        chk(wdt_dis_o == 1'b0, "R8", "watchdog enable after reset", wdt_dis_o, 0);
    endtask

    task automatic wait_run();
        int n = 0;
        bit bad = 1'b0;
        while (!running_o && n < 3000) begin
            if (sr_ipl_o != 3'd0) bad = 1'b1;
            step();
            n++;
        end
        chk(running_o == 1'b1, "R6", "running after vector load", running_o, 1);
        chk(!bad, "R6", "mask zero before last word", bad, 0);
        chk(sr_ipl_o == 3'd7, "R6", "mask level at run", sr_ipl_o, 7);
        chk(ssp_o == exp_ssp(), "R5", "stack pointer", ssp_o, exp_ssp());
        chk(pc_o == exp_pc(), "R5", "program counter", pc_o, exp_pc());
    endtask

    task automatic trig_wdt();
        @(negedge clk);
        wdt_ovf_i = 1'b1;
        @(negedge clk);
        wdt_ovf_i = 1'b0;
        #1;
        chk(global_rst_o == 1'b1, "R2", "watchdog pulse gives global reset", global_rst_o, 1);
        chk(running_o == 1'b0 && sr_ipl_o == 3'd0 && ssp_o == '0 && pc_o == '0, "R7",
            "state cleared by watchdog", {running_o, sr_ipl_o, ssp_o[15:0]}, 0);
    endtask

    task automatic trig_ext();
        int lat = -1;
        step();
        ext_rst_i = 1'b1;
        for (int i = 0; i < 2 + MCP + 2; i++) begin
            step();
            if (global_rst_o && lat < 0) lat = i + 1;
        end
        ext_rst_i = 1'b0;
        chk(lat > 0 && lat <= 2 + MCP + 1, "R2", "pin reset latency", lat, 2 + MCP + 1);
        while (global_rst_o) step();
    endtask

    task automatic trig_por();
        @(negedge clk);
        por_i = 1'b1;
        #1;
        chk(global_rst_o == 1'b1 && running_o == 1'b0, "R2", "power-on reset immediate",
            {global_rst_o, running_o}, 2'b10);
        repeat (3) step();
        @(negedge clk);
        por_i = 1'b0;
        #1;
    endtask

    task automatic abort_at(input int word);
        int n = 0;
        while (!(rd_req_o && exp_idx == word) && n < 2000) begin
            step();
            n++;
        end
        trig_wdt();
        chk(rd_req_o == 1'b0, "R7", "read request dropped on abort", rd_req_o, 0);
    endtask

    task automatic run_tests();
        bit seen;
        void'($urandom(32'd4711));
        new_vectors();
        repeat (3) step();
        // reset state while power-on is held
        chk(global_rst_o == 1'b1, "R2", "global reset during power-on", global_rst_o, 1);
        chk(wdt_dis_o == 1'b1, "R8", "watchdog disabled in reset", wdt_dis_o, 1);
        chk(periph_rst_o == 1'b1, "R9", "peripheral reset with global", periph_rst_o, 1);
        chk(running_o == 1'b0 && rd_req_o == 1'b0 && sr_ipl_o == 3'd0, "R6",
            "idle outputs in reset", {running_o, rd_req_o, sr_ipl_o}, 0);

        @(negedge clk);
        por_i = 1'b0;
        #1;
        check_hold("power-on");
        wait_run();

        // software reset touches only the peripherals
        sw_rst_i = 1'b1;
        #1;
        chk(periph_rst_o == 1'b1, "R9", "peripheral reset follows request", periph_rst_o, 1);
        repeat (5) step();
        chk(global_rst_o == 1'b0 && running_o == 1'b1, "R9", "processor untouched",
            {global_rst_o, running_o}, 2'b01);
        chk(ssp_o == exp_ssp() && pc_o == exp_pc(), "R9", "vectors untouched", pc_o, exp_pc());
        sw_rst_i = 1'b0;
        #1;
        chk(periph_rst_o == 1'b0, "R9", "peripheral reset released", periph_rst_o, 0);

        // watchdog restart with fresh vectors
        new_vectors();
        trig_wdt();
        check_hold("watchdog");
        wait_run();

        // one-clock pin pulse between strobes is ignored
        do step(); while (!mc_stb_i);
        ext_rst_i = 1'b1;
        step();
        ext_rst_i = 1'b0;
        seen = 1'b0;
        for (int i = 0; i < 12; i++) begin
            step();
            if (global_rst_o || !running_o) seen = 1'b1;
        end
        chk(!seen, "R1", "short pin pulse between strobes ignored", seen, 0);

        // held pin is accepted
        new_vectors();
        trig_ext();
        wait_run();

        // abort in the middle of the load, restart from word 0
        new_vectors();
        trig_wdt();
        abort_at(2);
        check_hold("abort");
        wait_run();

        // randomized mix
        for (int it = 0; it < 16; it++) begin
            new_vectors();
            rdy_pct = 20 + int'($urandom % 81);
            case ($urandom % 3)
                0: trig_wdt();
                1: trig_ext();
                default: trig_por();
            endcase
            if (($urandom % 3) == 0) abort_at(int'($urandom % 4));
            wait_run();
        end
    endtask

    initial begin
        fork
            strobe_gen();
            responder();
        join_none
        fork
            run_tests();
            begin
                repeat (150000) @(posedge clk);
                fails++;
                $display("FAIL watchdog (all requirements): actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule